// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block brings a single switchable power partition from off to running in a fixed, safe order, and takes it down again on request. A one-cycle start pulse launches the bring-up. The partition is held in reset and its clock is gated. Power is then requested and the block waits for the power-good handshake. Next the clock is enabled and a settle interval elapses. The clamps are then released, and once the clamp-released handshake arrives, reset is released as the very last step.

Every handshake wait is bounded. If a wait runs out, a sticky error flag is raised together with a 3-bit code naming the failed step. The block then unwinds the partition back to a safe, unpowered state, using an order that depends on how far the bring-up had progressed. A stop pulse while idle runs the same ordered power-down. Power is switched by a one-cycle toggle pulse toward an external switch. The pulse is sent only when the partition is not already in the wanted state.

Top module: `pd_bringup_seq`

## Requirements
- R1: After reset the outputs are as follows: part_rst_o=1, clk_en_o=0, pwr_toggle_o=0, clamp_rel_o=0, busy_o=0, done_o=0, err_o=0 and err_code_o=0.
- R2: A start pulse accepted while idle raises busy_o in the next cycle, keeps part_rst_o high, and drops clk_en_o one cycle later, before any power toggle.
- R3: In the power-on step a single one-cycle pwr_toggle_o pulse is issued if pwr_good_i is low. The block then waits for pwr_good_i high. If pwr_good_i is already high, no pulse is issued and the sequence moves on in the next cycle.
- R4: clk_en_o rises one cycle after power-good is seen, while reset is still held. The one-cycle clamp_rel_o pulse appears exactly SETTLE_CYC+1 cycles after clk_en_o rises, where SETTLE_CYC = CLK_MHZ*SETTLE_US.
- R5: part_rst_o falls only after clamp_done_i has been seen high, as the final step. In the cycle it falls, done_o=1 and busy_o=0.
- R6: Each handshake wait times out after POLL_CYC*MAX_POLLS cycles without the awaited level.
- R7: A power-on timeout sets err_code_o=1. The clock stays gated and reset stays asserted. A power-off toggle is sent only if pwr_good_i is high.
- R8: A clamp timeout sets err_code_o=2. The unwind gates the clock first, asserts reset in the next cycle, and toggles power in the cycle after that.
- R9: A stop pulse while idle runs the same order: clock off, reset on one cycle later, and a power toggle one cycle after that. done_o is cleared. A power-off timeout sets err_code_o=3.
- R10: Start and stop pulses that arrive while busy_o=1 have no effect.
- R11: err_o stays high until the next accepted start pulse. err_code_o keeps the code of the first failure, and err_code_o is nonzero whenever err_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle bring-up request |
| stop_i | input | 1 | One-cycle power-down request |
| pwr_good_i | input | 1 | Partition reports power present |
| clamp_done_i | input | 1 | Partition reports clamps released |
| part_rst_o | output | 1 | Partition reset, 1 = held in reset |
| clk_en_o | output | 1 | Partition clock enable |
| pwr_toggle_o | output | 1 | One-cycle pulse flipping the power switch |
| clamp_rel_o | output | 1 | One-cycle clamp release request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Partition brought up successfully |
| err_o | output | 1 | Sticky timeout flag |
| err_code_o | output | 3 | Failed step: 1 power on, 2 clamp, 3 power off |

## Verification
The bench builds the block with CLK_MHZ=1, SETTLE_US=5, POLL_CYC=2 and MAX_POLLS=4. This gives a 5-cycle settle and an 8-cycle bound on every wait. With these values each timeout, unwind order and sticky-error case completes within a few dozen cycles. A behavioural switch model and a clamp model answer the toggle and clamp pulses after fixed delays. Either model can be made to stall, which is how each of the three timeout steps is forced. A reference model is stepped in lockstep with the design and compared on every clock.

// File: rtl/pd_bringup_pkg.sv
package pd_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLKOFF, ST_PWR, ST_PWRWAIT, ST_CLKON, ST_SETTLE,
    ST_CLAMP, ST_CLAMPWAIT, ST_RSTOFF, ST_UWCLK, ST_UWRST, ST_UWPWR,
    ST_UWPWRWAIT
  } seq_state_e;

  localparam logic [2:0] FAULT_NONE    = 3'd0;
  localparam logic [2:0] FAULT_PWR_ON  = 3'd1;
  localparam logic [2:0] FAULT_CLAMP   = 3'd2;
  localparam logic [2:0] FAULT_PWR_OFF = 3'd3;

  // settle interval in cycles from clock rate and time
  function automatic int settle_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  // bound of one handshake wait in cycles
  function automatic int wait_cycles(input int polls, input int per_poll);
    return polls * per_poll;
  endfunction

  // counter width able to hold the larger of two intervals
  function automatic int count_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/pd_step_timer.sv
module pd_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pd_fault_latch.sv
module pd_fault_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       set,
  input  logic [2:0] code_in,
  output logic       err,
  output logic [2:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err  <= 1'b0;
      code <= 3'd0;
    end else if (clr) begin
      err  <= 1'b0;
      code <= 3'd0;
    end else if (set && !err) begin
      err  <= 1'b1;
      code <= code_in;
    end
  end
endmodule

// File: rtl/pd_bringup_seq.sv
module pd_bringup_seq
  import pd_bringup_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_US = 20,
  parameter int POLL_CYC  = 100,
  parameter int MAX_POLLS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       pwr_good_i,
  input  logic       clamp_done_i,
  output logic       part_rst_o,
  output logic       clk_en_o,
  output logic       pwr_toggle_o,
  output logic       clamp_rel_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [2:0] err_code_o
);
  localparam int SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);
  localparam int WAIT_CYC   = wait_cycles(MAX_POLLS, POLL_CYC);
  localparam int TW         = count_width(SETTLE_CYC, WAIT_CYC);
  localparam logic [TW-1:0] WAIT_LOAD   = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYC - 1);

  seq_state_e st_q, st_d;
  logic rst_q, rst_d, clk_q, clk_d, tog_q, tog_d, clr_q, clr_d, done_q, done_d;
  logic t_load, t_dec, t_zero;
  logic [TW-1:0] t_val;
  logic f_clr, f_set;
  logic [2:0] f_code;

  // named internal events for the checker
  logic ev_timeout, ev_clamp_ok, ev_start_take;

  pd_step_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .dec(t_dec), .zero(t_zero)
  );

  pd_fault_latch u_fault (
    .clk(clk), .rst_n(rst_n), .clr(f_clr), .set(f_set),
    .code_in(f_code), .err(err_o), .code(err_code_o)
  );

  always_comb begin
    st_d   = st_q;
    rst_d  = rst_q;
    clk_d  = clk_q;
    tog_d  = 1'b0;
    clr_d  = 1'b0;
    done_d = done_q;
    t_load = 1'b0;
    t_val  = WAIT_LOAD;
    t_dec  = 1'b0;
    f_clr  = 1'b0;
    f_set  = 1'b0;
    f_code = FAULT_NONE;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          rst_d  = 1'b1;
          f_clr  = 1'b1;
          done_d = 1'b0;
          st_d   = ST_CLKOFF;
        end else if (stop_i) begin
          done_d = 1'b0;
          st_d   = ST_UWCLK;
        end
      end
      ST_CLKOFF: begin
        clk_d = 1'b0;
        st_d  = ST_PWR;
      end
      ST_PWR: begin
        if (pwr_good_i) st_d = ST_CLKON;
        else begin
          tog_d  = 1'b1;
          t_load = 1'b1;
          st_d   = ST_PWRWAIT;
        end
      end
      ST_PWRWAIT: begin
        if (pwr_good_i) st_d = ST_CLKON;
        else if (t_zero) begin
          f_set  = 1'b1;
          f_code = FAULT_PWR_ON;
          st_d   = ST_UWPWR;
        end else t_dec = 1'b1;
      end
      ST_CLKON: begin
        clk_d  = 1'b1;
        t_load = 1'b1;
        t_val  = SETTLE_LOAD;
        st_d   = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (t_zero) st_d = ST_CLAMP;
        else t_dec = 1'b1;
      end
      ST_CLAMP: begin
        clr_d  = 1'b1;
        t_load = 1'b1;
        st_d   = ST_CLAMPWAIT;
      end
      ST_CLAMPWAIT: begin
        if (clamp_done_i) st_d = ST_RSTOFF;
        else if (t_zero) begin
          f_set  = 1'b1;
          f_code = FAULT_CLAMP;
          st_d   = ST_UWCLK;
        end else t_dec = 1'b1;
      end
      ST_RSTOFF: begin
        rst_d  = 1'b0;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_UWCLK: begin
        clk_d = 1'b0;
        st_d  = ST_UWRST;
      end
      ST_UWRST: begin
        rst_d = 1'b1;
        st_d  = ST_UWPWR;
      end
      ST_UWPWR: begin
        if (!pwr_good_i) st_d = ST_IDLE;
        else begin
          tog_d  = 1'b1;
          t_load = 1'b1;
          st_d   = ST_UWPWRWAIT;
        end
      end
      ST_UWPWRWAIT: begin
        if (!pwr_good_i) st_d = ST_IDLE;
        else if (t_zero) begin
          f_set  = 1'b1;
          f_code = FAULT_PWR_OFF;
          st_d   = ST_IDLE;
        end else t_dec = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rst_q  <= 1'b1;
      clk_q  <= 1'b0;
      tog_q  <= 1'b0;
      clr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rst_q  <= rst_d;
      clk_q  <= clk_d;
      tog_q  <= tog_d;
      clr_q  <= clr_d;
      done_q <= done_d;
    end
  end

  assign ev_timeout    = f_set;
  assign ev_clamp_ok   = (st_q == ST_CLAMPWAIT) && clamp_done_i;
  assign ev_start_take = (st_q == ST_IDLE) && start_i;

  assign part_rst_o   = rst_q;
  assign clk_en_o     = clk_q;
  assign pwr_toggle_o = tog_q;
  assign clamp_rel_o  = clr_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
endmodule

// File: rtl/pd_bringup_chk.sv
module pd_bringup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       part_rst_o,
  input logic       clk_en_o,
  input logic       pwr_toggle_o,
  input logic       clamp_rel_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [2:0] err_code_o,
  input logic       ev_timeout,
  input logic       ev_clamp_ok,
  input logic       ev_start_take
);
  p_tog_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_toggle_o |=> !pwr_toggle_o);

  p_tog_clk_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_toggle_o |-> !clk_en_o);

  p_clk_rise_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> part_rst_o);

  p_clamp_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_rel_o |-> (clk_en_o && part_rst_o));

  p_rst_release_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(part_rst_o) |-> (done_o && clk_en_o && !busy_o));

  p_clamp_then_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clamp_ok |=> ##1 !part_rst_o);

  p_err_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(ev_timeout));

  p_err_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o != 3'd0));

  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_take |=> (!err_o && busy_o && part_rst_o));
endmodule

bind pd_bringup_seq pd_bringup_chk i_chk (
  .clk(clk), .rst_n(rst_n), .part_rst_o(part_rst_o), .clk_en_o(clk_en_o),
  .pwr_toggle_o(pwr_toggle_o), .clamp_rel_o(clamp_rel_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
  .ev_timeout(ev_timeout), .ev_clamp_ok(ev_clamp_ok),
  .ev_start_take(ev_start_take)
);

// File: tb/test_pd_bringup_seq.sv
module test_pd_bringup_seq;
  localparam int PERIOD   = 10;
  localparam int MHZ      = 1;
  localparam int S_US     = 5;
  localparam int POLL     = 2;
  localparam int NPOLL    = 4;
  localparam int SETTLE   = MHZ * S_US;   // 5 cycles
  localparam int LIMIT    = POLL * NPOLL; // 8 cycles
  localparam int SW_DLY   = 3;
  localparam int CL_DLY   = 2;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic pg_r = 1'b0, cd_r = 1'b0;
  logic part_rst_o, clk_en_o, pwr_toggle_o, clamp_rel_o, busy_o, done_o, err_o;
  logic [2:0] err_code_o;

  always #(PERIOD/2) clk = ~clk;

  pd_bringup_seq #(.CLK_MHZ(MHZ), .SETTLE_US(S_US), .POLL_CYC(POLL),
                   .MAX_POLLS(NPOLL)) i_pd_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .pwr_good_i(pg_r), .clamp_done_i(cd_r), .part_rst_o(part_rst_o),
    .clk_en_o(clk_en_o), .pwr_toggle_o(pwr_toggle_o), .clamp_rel_o(clamp_rel_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit sw_stuck = 0, cl_stuck = 0, pg_force = 0;
  int sw_pend = 0, cl_pend = 0;
  int tog_cyc = 0, clr_cyc = 0, clk_rise = 0, clk_fall = 0, rst_rise = 0, err_rise = 0;
  int tog_cnt = 0;
  logic p_clk = 0, p_rst = 1, p_err = 0;

  // inputs as seen by the design at the last rising edge
  logic s_start = 0, s_stop = 0, s_pg = 0, s_cd = 0;
  always @(posedge clk) begin
    s_start <= start_i; s_stop <= stop_i; s_pg <= pg_r; s_cd <= cd_r;
  end

  // reference model: phase names are bench-local
  typedef enum int {M_IDLE, M_GATE, M_POW, M_POWW, M_CLKEN, M_SET, M_CLAMP, M_CLW,
                    M_REL, M_DCLK, M_DRST, M_DPOW, M_DPW} mph_e;
  mph_e m_ph = M_IDLE;
  int m_el = 0;
  bit m_rst = 1, m_clk = 0, m_tog = 0, m_clr = 0, m_done = 0, m_err = 0;
  int m_code = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic m_fault(input int c);
    if (!m_err) begin m_err = 1; m_code = c; end
  endtask

  task automatic m_step();
    m_tog = 0; m_clr = 0;
    case (m_ph)
      M_IDLE: if (s_start) begin
                m_rst = 1; m_err = 0; m_code = 0; m_done = 0; m_ph = M_GATE;
              end else if (s_stop) begin m_done = 0; m_ph = M_DCLK; end
      M_GATE: begin m_clk = 0; m_ph = M_POW; end
      M_POW:  if (s_pg) m_ph = M_CLKEN; else begin m_tog = 1; m_el = 0; m_ph = M_POWW; end
      M_POWW: if (s_pg) m_ph = M_CLKEN;
              else if (m_el == LIMIT-1) begin m_fault(1); m_ph = M_DPOW; end
              else m_el++;
      M_CLKEN: begin m_clk = 1; m_el = 0; m_ph = M_SET; end
      M_SET:  if (m_el == SETTLE-1) m_ph = M_CLAMP; else m_el++;
      M_CLAMP: begin m_clr = 1; m_el = 0; m_ph = M_CLW; end
      M_CLW:  if (s_cd) m_ph = M_REL;
              else if (m_el == LIMIT-1) begin m_fault(2); m_ph = M_DCLK; end
              else m_el++;
      M_REL:  begin m_rst = 0; m_done = 1; m_ph = M_IDLE; end
      M_DCLK: begin m_clk = 0; m_ph = M_DRST; end
      M_DRST: begin m_rst = 1; m_ph = M_DPOW; end
      M_DPOW: if (!s_pg) m_ph = M_IDLE; else begin m_tog = 1; m_el = 0; m_ph = M_DPW; end
      M_DPW:  if (!s_pg) m_ph = M_IDLE;
              else if (m_el == LIMIT-1) begin m_fault(3); m_ph = M_IDLE; end
              else m_el++;
      default: m_ph = M_IDLE;
    endcase
  endtask

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      check(0, "WATCHDOG", "cycles", cyc, WD_LIMIT);
      summary_and_end();
    end
    if (!rst_n) begin
      m_ph = M_IDLE; m_rst = 1; m_clk = 0; m_tog = 0; m_clr = 0;
      m_done = 0; m_err = 0; m_code = 0; m_el = 0;
    end else begin
      m_step();
      n_chk++;
      if (part_rst_o !== m_rst || clk_en_o !== m_clk || pwr_toggle_o !== m_tog ||
          clamp_rel_o !== m_clr || busy_o !== (m_ph != M_IDLE) || done_o !== m_done ||
          err_o !== m_err || err_code_o !== 3'(m_code)) begin
        n_fail++;
        $display("FAIL R2/R4/R5/R7/R8/R9/R10 lockstep cyc %0d: actual rst%0d clk%0d tog%0d clr%0d busy%0d done%0d err%0d code%0d expected rst%0d clk%0d tog%0d clr%0d busy%0d done%0d err%0d code%0d",
                 cyc, part_rst_o, clk_en_o, pwr_toggle_o, clamp_rel_o, busy_o, done_o,
                 err_o, err_code_o, m_rst, m_clk, m_tog, m_clr, m_ph != M_IDLE, m_done,
                 m_err, m_code);
      end
    end
    // event log
    if (pwr_toggle_o) begin tog_cyc = cyc; tog_cnt++; end
    if (clamp_rel_o) clr_cyc = cyc;
    if (clk_en_o && !p_clk) clk_rise = cyc;
    if (!clk_en_o && p_clk) clk_fall = cyc;
    if (part_rst_o && !p_rst) rst_rise = cyc;
    if (err_o && !p_err) err_rise = cyc;
    p_clk = clk_en_o; p_rst = part_rst_o; p_err = err_o;
    // switch and clamp environment
    if (pg_force) begin pg_r = 1; pg_force = 0; sw_pend = 0; end
    else if (pwr_toggle_o && !sw_stuck) sw_pend = SW_DLY;
    else if (sw_pend > 0) begin sw_pend--; if (sw_pend == 0) pg_r = !pg_r; end
    if (!pg_r) begin cd_r = 0; cl_pend = 0; end
    else if (clamp_rel_o && !cl_stuck) cl_pend = CL_DLY;
    else if (cl_pend > 0) begin cl_pend--; if (cl_pend == 0) cd_r = 1; end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1;
    @(posedge clk); #1 start_i = 0;
  endtask

  task automatic pulse_stop();
    @(posedge clk); #1 stop_i = 1;
    @(posedge clk); #1 stop_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy_o; i++) @(posedge clk);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(part_rst_o == 1 && clk_en_o == 0 && pwr_toggle_o == 0 && clamp_rel_o == 0,
          "R1", "reset outputs", {part_rst_o, clk_en_o, pwr_toggle_o, clamp_rel_o}, 4'b1000);
    check(busy_o == 0 && done_o == 0 && err_o == 0 && err_code_o == 0,
          "R1", "reset status", {busy_o, done_o, err_o, err_code_o}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // normal bring-up
    tog_cnt = 0;
    pulse_start();
    check(busy_o == 1, "R2", "busy after start", busy_o, 1);
    wait_idle();
    check(done_o && !part_rst_o && clk_en_o, "R5", "up state",
          {done_o, part_rst_o, clk_en_o}, 3'b101);
    check(tog_cnt == 1, "R3", "one power toggle", tog_cnt, 1);
    check(clr_cyc - clk_rise == SETTLE + 1, "R4", "settle to clamp", clr_cyc - clk_rise, SETTLE + 1);

    // ordered power-down
    tog_cnt = 0;
    pulse_stop();
    wait_idle();
    check(rst_rise - clk_fall == 1, "R9", "reset after clock off", rst_rise - clk_fall, 1);
    check(tog_cyc - clk_fall == 2, "R9", "toggle after reset", tog_cyc - clk_fall, 2);
    check(!done_o && !pg_r && tog_cnt == 1, "R9", "down state", {done_o, pg_r}, 0);

    // already powered: no request issued
    @(posedge clk); #1 pg_force = 1;
    repeat (2) @(posedge clk);
    tog_cnt = 0;
    pulse_start();
    wait_idle();
    check(tog_cnt == 0, "R3", "no toggle when powered", tog_cnt, 0);
    check(done_o == 1, "R3", "done when powered", done_o, 1);
    pulse_stop();
    wait_idle();

    // start and stop while busy are ignored
    tog_cnt = 0;
    pulse_start();
    repeat (4) @(posedge clk);
    pulse_start();
    pulse_stop();
    wait_idle();
    check(done_o && tog_cnt == 1 && !err_o, "R10", "pulses while busy",
          {done_o, err_o, 4'(tog_cnt)}, 6'b100001);
    pulse_stop();
    wait_idle();

    // power-on timeout
    sw_stuck = 1;
    tog_cnt = 0;
    pulse_start();
    wait_idle();
    check(err_o && err_code_o == 3'd1, "R7", "power-on fault code", err_code_o, 1);
    check(!clk_en_o && part_rst_o, "R7", "gated and in reset", {clk_en_o, part_rst_o}, 2'b01);
    check(tog_cnt == 1, "R7", "no off toggle when unpowered", tog_cnt, 1);
    check(err_rise - tog_cyc == LIMIT, "R6", "wait bound", err_rise - tog_cyc, LIMIT);

    // sticky error, stop in idle does not clear it
    repeat (5) @(posedge clk);
    pulse_stop();
    wait_idle();
    check(err_o && err_code_o == 3'd1, "R11", "sticky after stop", err_code_o, 1);
    sw_stuck = 0;
    pulse_start();
    check(!err_o && err_code_o == 0, "R11", "cleared by start", err_o, 0);
    wait_idle();
    check(done_o == 1, "R11", "recovered bring-up", done_o, 1);
    pulse_stop();
    wait_idle();

    // clamp timeout
    cl_stuck = 1;
    tog_cnt = 0;
    pulse_start();
    wait_idle();
    check(err_o && err_code_o == 3'd2, "R8", "clamp fault code", err_code_o, 2);
    check(tog_cyc - clk_fall == 2, "R8", "unwind order", tog_cyc - clk_fall, 2);
    check(!pg_r && !clk_en_o && part_rst_o && tog_cnt == 2, "R8", "unwound",
          {pg_r, clk_en_o, part_rst_o}, 3'b001);
    cl_stuck = 0;

    // power-off timeout
    pulse_start();
    wait_idle();
    check(done_o && !err_o, "R5", "up again", {done_o, err_o}, 2'b10);
    sw_stuck = 1;
    pulse_stop();
    wait_idle();
    check(err_o && err_code_o == 3'd3, "R9", "power-off fault code", err_code_o, 3);
    check(err_rise - tog_cyc == LIMIT, "R6", "off wait bound", err_rise - tog_cyc, LIMIT);

    summary_and_end();
  end
endmodule